// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Front-End

This block is the processor-facing register layer of a serial controller that has two channels, called A and B. A byte-wide bus reaches both channels through one small address window. Two address bits choose the channel and choose between its control port and its data port. Their position is set by a stride parameter, so the same RTL serves layouts with registers one byte apart or spaced wider. The block holds the settings each channel needs. It takes events from the serial datapath: received bytes, a transmit buffer becoming empty, and line breaks. It merges every enabled source into one interrupt line. The shifter, the baud generator and the line drivers are outside this block. It tells them about new settings only through a per-channel "parameters changed" strobe.

Software reaches any channel register through a two-step pointer sequence on the control port. Each channel runs a small state machine with two states. PTR_ZERO is the idle state. In it, a control access targets register 0. A control write whose low nibble is non-zero loads that nibble as the pointer and moves to PTR_SET (the transition "arm"). In PTR_SET, the next control read or write targets the pointed register and returns to PTR_ZERO (the transition "consume"). A control write with a zero low nibble in PTR_ZERO stays in PTR_ZERO. A channel reset or the block reset forces PTR_ZERO from either state.

Registers written through the pointer: 1 holds the interrupt enables, with bit 0 for receive and bit 1 for transmit. Registers 3, 4 and 5 hold line settings. Register 9 is the master command. Registers 12 and 13 hold the divisor low and high bytes. Registers read through the pointer: 0 is status, 3 is the shared pending register, and 12 and 13 return the divisor bytes. Any other read returns 0.

Top module: `sercom_regif`

## Requirements
- R1: With stride S, address bit S selects data (1) or control (0), and bit S+1 selects the channel, where 1 is channel A and 0 is channel B. Accesses at addresses of 4<<S and above have no effect. For such an access, bus_rdata reads 0 and no strobe fires.
- R2: The pointer works as described above. A control write with a non-zero low nibble in PTR_ZERO loads the pointer. The next control access targets that register. After that access, control accesses target register 0 again.
- R3: Writing register 12 or 13 stores the divisor low or high byte. Reading register 12 or 13 returns the stored byte.
- R4: A write to register 3, 4, 5, 12 or 13 pulses param_strobe for that channel during the write cycle. Any other write leaves param_strobe low.
- R5: Bits [7:6] of a register 9 write form a reset command. 00 does nothing. 01 resets channel B, 10 resets channel A, and 11 resets both channels. A reset clears that channel's enables, divisor, pending flags, break flag and receive buffer, and returns its pointer to PTR_ZERO. The other channel is left unchanged.
- R6: irq is 1 when, for either channel, one of these holds: the receive enable and the receive pending flag are both set; the transmit enable and the transmit pending flag are both set; or the break flag is set.
- R7: Register 3 read on channel A is the shared pending register. Bit 5 is receive pending for A, bit 4 is transmit pending for A, bit 2 is receive pending for B, and bit 1 is transmit pending for B. All other bits are 0. Register 3 read on channel B returns 0.
- R8: In register 3, receive has priority. A channel's transmit bit shows only while that channel has no receive pending. Clearing the receive flag shows the transmit bit again if transmit is still pending.
- R9: A line_brk pulse sets the channel's break flag. The flag shows in status bit 7 and raises irq whatever the enables are. The flag stays set until that channel is reset.
- R10: A data write pulses tx_strobe for the selected channel during the write cycle, with tx_byte equal to the written byte. It also clears that channel's transmit pending flag. A tx_done pulse sets that flag.
- R11: An rx_push pulse stores the byte and sets receive pending. A data read returns the stored byte and clears receive pending. In the status register, bit 0 is receive pending and bit 2 is transmit pending.
- R12: A synchronous active-high rst clears all registers and flags, and leaves irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wr | input | 1 | Write access this cycle |
| bus_rd | input | 1 | Read access this cycle (ignored during a write) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| rx_push | input | 2 | Received-byte event per channel (index 1 = A) |
| rx_bytes | input | 16 | Received bytes, channel c in bits [8c+7:8c] |
| line_brk | input | 2 | Break detected per channel |
| tx_done | input | 2 | Transmit buffer emptied per channel |
| tx_strobe | output | 2 | Data byte written per channel |
| tx_byte | output | 8 | Byte to transmit |
| param_strobe | output | 2 | Line settings changed per channel |
| irq | output | 1 | Shared interrupt request |

## Verification
Assertions check the following on every cycle:
- the pointer returns to PTR_ZERO after a consuming access;
- the divisor byte is stored;
- a data read clears receive pending;
- the break flag is sticky;
- the two tx_strobe bits are never both high;
- a reset, or a reset-both command with no new events, leaves irq low.

Only the bench's scenarios can show the cross-channel behaviour:
- the pending bits of channel B appearing in channel A's register 3;
- receive taking priority over transmit in that register;
- a reset command on one channel leaving the other channel's registers intact.

The random phase mixes events, enables, data traffic and reset commands. It compares irq and the shared pending register against a bench model after every step.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
    localparam int DW     = 8;
    localparam int NCH    = 2;
    localparam int PTR_W  = 4;

    typedef enum logic {PTR_ZERO, PTR_SET} ptr_state_e;

    typedef enum logic [1:0] {
        RSTC_NONE = 2'b00,
        RSTC_B    = 2'b01,
        RSTC_A    = 2'b10,
        RSTC_BOTH = 2'b11
    } rst_cmd_e;

    localparam logic [PTR_W-1:0] REG_STAT   = 4'd0;
    localparam logic [PTR_W-1:0] REG_IEN    = 4'd1;
    localparam logic [PTR_W-1:0] REG_RXCFG  = 4'd3;
    localparam logic [PTR_W-1:0] REG_PEND   = 4'd3;
    localparam logic [PTR_W-1:0] REG_MODE   = 4'd4;
    localparam logic [PTR_W-1:0] REG_TXCFG  = 4'd5;
    localparam logic [PTR_W-1:0] REG_MASTER = 4'd9;
    localparam logic [PTR_W-1:0] REG_DIVLO  = 4'd12;
    localparam logic [PTR_W-1:0] REG_DIVHI  = 4'd13;
endpackage

// File: rtl/sercom_decode.sv
module sercom_decode #(
    parameter int ADDR_W       = 4,
    parameter int STRIDE_SHIFT = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic              is_data,
    output logic              chan
);
    localparam int TOP_LSB = STRIDE_SHIFT + 2;

    assign is_data = addr[STRIDE_SHIFT];
    assign chan    = addr[STRIDE_SHIFT+1];

    generate
        if (TOP_LSB >= ADDR_W) begin : g_full
            assign in_win = 1'b1;
        end else begin : g_window
            assign in_win = (addr[ADDR_W-1:TOP_LSB] == '0);
        end
        if (STRIDE_SHIFT > 0) begin : g_low
            logic unused_low;
            assign unused_low = ^addr[STRIDE_SHIFT-1:0];
        end
    endgenerate
endmodule

// File: rtl/sercom_chan.sv
module sercom_chan
    import sercom_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          acc_wr,
    input  logic          acc_rd,
    input  logic          is_data,
    input  logic [DW-1:0] wdata,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_byte,
    input  logic          line_brk,
    input  logic          tx_done,
    input  logic [DW-1:0] pend_view,
    output logic [DW-1:0] rdata,
    output logic          tx_strobe,
    output logic          param_strobe,
    output logic [1:0]    rst_req,
    output logic          ie_rx,
    output logic          ie_tx,
    output logic          rx_pend,
    output logic          tx_pend,
    output logic          brk
);
    ptr_state_e       st_q, st_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [1:0]       ien_q;
    logic [DW-1:0]    div_lo_q, div_hi_q, rx_buf_q;
    logic             rx_pend_q, tx_pend_q, brk_q;

    logic ctrl_wr, ctrl_rd, data_wr, data_rd, reg_we, master_hit, store;
    logic [PTR_W-1:0] tgt;

    assign ctrl_wr = acc_wr & ~is_data;
    assign ctrl_rd = acc_rd & ~is_data;
    assign data_wr = acc_wr & is_data;
    assign data_rd = acc_rd & is_data;
    assign tgt     = (st_q == PTR_SET) ? ptr_q : REG_STAT;

    // pointer state machine: next state
    always_comb begin
        st_d  = st_q;
        ptr_d = ptr_q;
        unique case (st_q)
            PTR_ZERO: begin
                if (ctrl_wr && wdata[PTR_W-1:0] != '0) begin
                    st_d  = PTR_SET;
                    ptr_d = wdata[PTR_W-1:0];
                end
            end
            PTR_SET: begin
                if (ctrl_wr || ctrl_rd) begin
                    st_d  = PTR_ZERO;
                    ptr_d = '0;
                end
            end
            default: begin
                st_d  = PTR_ZERO;
                ptr_d = '0;
            end
        endcase
    end

    // pointer state machine: state register
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q  <= PTR_ZERO;
            ptr_q <= '0;
        end else begin
            st_q  <= st_d;
            ptr_q <= ptr_d;
        end
    end

    // register write decode
    assign reg_we       = ctrl_wr && (st_q == PTR_SET);
    assign master_hit   = reg_we && (ptr_q == REG_MASTER);
    assign rst_req      = master_hit ? wdata[7:6] : 2'b00;
    assign store        = reg_we && !(master_hit && wdata[7:6] != 2'b00);
    assign param_strobe = reg_we && (ptr_q == REG_RXCFG || ptr_q == REG_MODE ||
                                     ptr_q == REG_TXCFG || ptr_q == REG_DIVLO ||
                                     ptr_q == REG_DIVHI);
    assign tx_strobe    = data_wr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ien_q    <= '0;
            div_lo_q <= '0;
            div_hi_q <= '0;
        end else if (store) begin
            if (ptr_q == REG_IEN)   ien_q    <= wdata[1:0];
            if (ptr_q == REG_DIVLO) div_lo_q <= wdata;
            if (ptr_q == REG_DIVHI) div_hi_q <= wdata;
        end
    end

    // event flags
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rx_pend_q <= 1'b0;
            tx_pend_q <= 1'b0;
            brk_q     <= 1'b0;
            rx_buf_q  <= '0;
        end else begin
            if (rx_push) begin
                rx_pend_q <= 1'b1;
                rx_buf_q  <= rx_byte;
            end else if (data_rd) begin
                rx_pend_q <= 1'b0;
            end
            if (tx_done)      tx_pend_q <= 1'b1;
            else if (data_wr) tx_pend_q <= 1'b0;
            if (line_brk)     brk_q     <= 1'b1;
        end
    end

    // read mux
    always_comb begin
        if (is_data) begin
            rdata = rx_buf_q;
        end else begin
            unique case (tgt)
                REG_STAT:  rdata = {brk_q, 4'b0000, tx_pend_q, 1'b0, rx_pend_q};
                REG_PEND:  rdata = pend_view;
                REG_DIVLO: rdata = div_lo_q;
                REG_DIVHI: rdata = div_hi_q;
                default:   rdata = '0;
            endcase
        end
    end

    assign ie_rx   = ien_q[0];
    assign ie_tx   = ien_q[1];
    assign rx_pend = rx_pend_q;
    assign tx_pend = tx_pend_q;
    assign brk     = brk_q;

    // R2
    ptr_return_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_wr || ctrl_rd) && st_q == PTR_SET && !clr) |=> (st_q == PTR_ZERO));

    // R3
    div_store_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && ptr_q == REG_DIVLO && !clr) |=> (div_lo_q == $past(wdata)));

    // R11
    rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !rx_push && !clr) |=> !rx_pend_q);

    // R9
    brk_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_q && !clr) |=> brk_q);
endmodule

// File: rtl/sercom_irq.sv
module sercom_irq
    import sercom_pkg::*;
(
    input  logic [NCH-1:0] ie_rx,
    input  logic [NCH-1:0] ie_tx,
    input  logic [NCH-1:0] rx_pend,
    input  logic [NCH-1:0] tx_pend,
    input  logic [NCH-1:0] brk,
    output logic [DW-1:0]  pend_reg,
    output logic           irq
);
    logic [NCH-1:0] req;
    logic [NCH-1:0] tx_show;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_req
            assign req[c]     = (ie_rx[c] & rx_pend[c]) | (ie_tx[c] & tx_pend[c]) | brk[c];
            assign tx_show[c] = tx_pend[c] & ~rx_pend[c];
        end
    endgenerate

    assign irq      = |req;
    assign pend_reg = {2'b00, rx_pend[1], tx_show[1], 1'b0, rx_pend[0], tx_show[0], 1'b0};
endmodule

// File: rtl/sercom_regif.sv
module sercom_regif
    import sercom_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int STRIDE_SHIFT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [1:0]        rx_push,
    input  logic [15:0]       rx_bytes,
    input  logic [1:0]        line_brk,
    input  logic [1:0]        tx_done,
    output logic [1:0]        tx_strobe,
    output logic [7:0]        tx_byte,
    output logic [1:0]        param_strobe,
    output logic              irq
);
    logic in_win, is_data, chan;
    logic rd_hit;
    logic [NCH-1:0] acc_wr, acc_rd, ie_rx, ie_tx, rx_pend, tx_pend, brk, clr;
    logic [1:0]     rst_req [NCH];
    logic [DW-1:0]  chan_rd [NCH];
    logic [DW-1:0]  pend_reg;
    rst_cmd_e       cmd;

    sercom_decode #(.ADDR_W(ADDR_W), .STRIDE_SHIFT(STRIDE_SHIFT)) u_dec (
        .addr(bus_addr), .in_win(in_win), .is_data(is_data), .chan(chan)
    );

    assign rd_hit = bus_rd & ~bus_wr & in_win;
    assign cmd    = rst_cmd_e'(rst_req[0] | rst_req[1]);
    assign clr    = cmd;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign acc_wr[c] = bus_wr & in_win & (chan == c[0]);
            assign acc_rd[c] = rd_hit & (chan == c[0]);

            sercom_chan u_chan (
                .clk(clk), .rst(rst), .clr(clr[c]),
                .acc_wr(acc_wr[c]), .acc_rd(acc_rd[c]), .is_data(is_data),
                .wdata(bus_wdata),
                .rx_push(rx_push[c]), .rx_byte(rx_bytes[c*DW +: DW]),
                .line_brk(line_brk[c]), .tx_done(tx_done[c]),
                .pend_view((c == 1) ? pend_reg : 8'h00),
                .rdata(chan_rd[c]), .tx_strobe(tx_strobe[c]),
                .param_strobe(param_strobe[c]), .rst_req(rst_req[c]),
                .ie_rx(ie_rx[c]), .ie_tx(ie_tx[c]),
                .rx_pend(rx_pend[c]), .tx_pend(tx_pend[c]), .brk(brk[c])
            );
        end
    endgenerate

    sercom_irq u_irq (
        .ie_rx(ie_rx), .ie_tx(ie_tx), .rx_pend(rx_pend), .tx_pend(tx_pend),
        .brk(brk), .pend_reg(pend_reg), .irq(irq)
    );

    assign bus_rdata = rd_hit ? chan_rd[chan] : 8'h00;
    assign tx_byte   = bus_wdata;

    // R12
    rst_quiet_chk: assert property (@(posedge clk) rst |=> !irq);

    // R5
    rst_both_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == RSTC_BOTH && rx_push == 2'b00 && tx_done == 2'b00 && line_brk == 2'b00)
        |=> !irq);

    // R10
    tx_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tx_strobe));
endmodule

// File: tb/sim_sercom_regif.sv
module sim_sercom_regif;
    localparam int S = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] rx_push = '0, line_brk = '0, tx_done = '0;
    logic [15:0] rx_bytes = '0;
    logic [1:0] tx_strobe, param_strobe;
    logic [7:0] tx_byte;
    logic       irq;

    int checks = 0;
    int errs   = 0;

    // bench model, index 1 = channel A
    logic       m_rx [2];
    logic       m_tx [2];
    logic       m_brk [2];
    logic [1:0] m_ien [2];
    logic [7:0] m_buf [2];

    always #4 clk = ~clk;

    sercom_regif #(.ADDR_W(4), .STRIDE_SHIFT(S)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_push(rx_push),
        .rx_bytes(rx_bytes), .line_brk(line_brk), .tx_done(tx_done),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte), .param_strobe(param_strobe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] adr(input int ch, input bit dat);
        return 4'((ch << (S + 1)) | (int'(dat) << S));
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int c = 0; c < 2; c++)
            r |= (m_ien[c][0] & m_rx[c]) | (m_ien[c][1] & m_tx[c]) | m_brk[c];
        return r;
    endfunction

    function automatic logic [7:0] exp_pend();
        return {2'b00, m_rx[1], m_tx[1] & ~m_rx[1], 1'b0, m_rx[0], m_tx[0] & ~m_rx[0], 1'b0};
    endfunction

    function automatic logic [7:0] exp_stat(input int c);
        return {m_brk[c], 4'b0000, m_tx[c], 1'b0, m_rx[c]};
    endfunction

    function automatic void model_clear(input int c);
        m_rx[c] = 0; m_tx[c] = 0; m_brk[c] = 0; m_ien[c] = 0; m_buf[c] = 0;
    endfunction

    // one bus cycle, starting just after a falling edge
    task automatic acc(input logic [3:0] a, input logic w, input logic r, input logic [7:0] d,
                       output logic [7:0] rd, output logic [1:0] txs, output logic [1:0] ps);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        #1;
        rd = bus_rdata; txs = tx_strobe; ps = param_strobe;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic wreg(input int ch, input logic [3:0] r, input logic [7:0] v,
                        output logic [1:0] ps);
        logic [7:0] rd; logic [1:0] txs;
        acc(adr(ch, 0), 1, 0, {4'h0, r}, rd, txs, ps);
        acc(adr(ch, 0), 1, 0, v, rd, txs, ps);
    endtask

    task automatic rreg(input int ch, input logic [3:0] r, output logic [7:0] v);
        logic [7:0] rd; logic [1:0] txs, ps;
        acc(adr(ch, 0), 1, 0, {4'h0, r}, rd, txs, ps);
        acc(adr(ch, 0), 0, 1, 8'h00, v, txs, ps);
    endtask

    task automatic event_pulse(input logic [1:0] push, input logic [15:0] bytes,
                               input logic [1:0] txd, input logic [1:0] br);
        rx_push = push; rx_bytes = bytes; tx_done = txd; line_brk = br;
        @(negedge clk);
        rx_push = 0; tx_done = 0; line_brk = 0;
        for (int c = 0; c < 2; c++) begin
            if (push[c]) begin m_rx[c] = 1; m_buf[c] = bytes[c*8 +: 8]; end
            if (txd[c]) m_tx[c] = 1;
            if (br[c])  m_brk[c] = 1;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic [1:0] txs, ps;
        void'($urandom(32'd1234));
        for (int c = 0; c < 2; c++) model_clear(c);
        repeat (3) @(negedge clk);
        rst = 0;

        // R12 reset state
        #1 chk("R12 irq after reset", irq, 0);
        rreg(1, 4'd3, v);  chk("R12 pend after reset", v, 0);
        rreg(0, 4'd12, v); chk("R12 divisor after reset", v, 0);

        // R1 decode
        acc(4'd8, 1, 0, 8'h55, v, txs, ps); chk("R1 outside window no strobe", txs, 0);
        acc(4'd9, 0, 1, 8'h00, v, txs, ps); chk("R1 outside window reads 0", v, 0);
        acc(adr(1, 1), 1, 0, 8'hA7, v, txs, ps);
        chk("R1 R10 channel A data strobe", txs, 2'b10);
        chk("R10 tx byte", tx_byte, 8'hA7);
        acc(adr(0, 1), 1, 0, 8'h3C, v, txs, ps);
        chk("R1 R10 channel B data strobe", txs, 2'b01);

        // R2 R3 R4
        wreg(0, 4'd12, 8'h5A, ps); chk("R4 divisor low strobe", ps, 2'b01);
        wreg(1, 4'd13, 8'hC3, ps); chk("R4 divisor high strobe on A", ps, 2'b10);
        wreg(1, 4'd12, 8'h11, ps);
        rreg(0, 4'd12, v); chk("R3 divisor low readback B", v, 8'h5A);
        rreg(1, 4'd13, v); chk("R3 divisor high readback A", v, 8'hC3);
        acc(adr(0, 0), 0, 1, 8'h00, v, txs, ps);
        chk("R2 pointer back to status", v, exp_stat(0));
        wreg(0, 4'd4, 8'h44, ps); chk("R4 mode write strobe", ps, 2'b01);
        wreg(0, 4'd2, 8'h44, ps); chk("R4 other register no strobe", ps, 2'b00);
        acc(adr(0, 0), 1, 0, 8'h05, v, txs, ps);
        chk("R4 pointer arm no strobe", ps, 2'b00);
        acc(adr(0, 0), 1, 0, 8'h77, v, txs, ps);
        chk("R2 armed write hits register 5", ps, 2'b01);
        rreg(0, 4'd3, v); chk("R7 channel B pend reads 0", v, 0);

        // R5 reset commands
        wreg(1, 4'd9, 8'h00, ps);
        rreg(1, 4'd12, v); chk("R5 command none keeps A", v, 8'h11);
        wreg(1, 4'd9, 8'h40, ps);
        model_clear(0);
        rreg(0, 4'd12, v); chk("R5 reset B clears B divisor", v, 0);
        rreg(1, 4'd13, v); chk("R5 reset B keeps A divisor", v, 8'hC3);
        wreg(0, 4'd9, 8'h80, ps);
        model_clear(1);
        rreg(1, 4'd13, v); chk("R5 reset A from B port", v, 0);

        // R8 priority and restore
        event_pulse(2'b10, 16'h9E00, 2'b10, 2'b00);
        rreg(1, 4'd3, v); chk("R8 rx hides tx", v, 8'h20);
        acc(adr(1, 1), 0, 1, 8'h00, v, txs, ps);
        chk("R11 data read byte", v, 8'h9E);
        m_rx[1] = 0;
        rreg(1, 4'd3, v); chk("R8 tx restored", v, 8'h10);
        chk("R6 no enable no irq", irq, 0);
        wreg(1, 4'd1, 8'h02, ps); m_ien[1] = 2'b10;
        #1 chk("R6 tx enable irq", irq, 1);

        // R9 break
        wreg(1, 4'd1, 8'h00, ps); m_ien[1] = 0;
        event_pulse(2'b00, 16'h0000, 2'b00, 2'b01);
        #1 chk("R9 break irq", irq, 1);
        rreg(0, 4'd0, v); chk("R9 break status", v, 8'h80);
        wreg(0, 4'd9, 8'hC0, ps);
        model_clear(0); model_clear(1);
        #1 chk("R5 reset both clears irq", irq, 0);

        // random phase
        for (int i = 0; i < 400; i++) begin
            int op = $urandom % 8;
            int ch = $urandom % 2;
            logic [7:0] b = 8'($urandom);
            case (op)
                0: event_pulse(ch ? 2'b10 : 2'b01, {b, b}, 2'b00, 2'b00);
                1: event_pulse(2'b00, 16'h0000, ch ? 2'b10 : 2'b01, 2'b00);
                2: begin
                    acc(adr(ch, 1), 0, 1, 8'h00, v, txs, ps);
                    chk("R11 random data read", v, m_buf[ch]);
                    m_rx[ch] = 0;
                end
                3: begin
                    acc(adr(ch, 1), 1, 0, b, v, txs, ps);
                    chk("R10 random data strobe", txs, ch ? 2'b10 : 2'b01);
                    m_tx[ch] = 0;
                end
                4: begin
                    wreg(ch, 4'd1, {6'b0, b[1:0]}, ps);
                    chk("R4 enable write no strobe", ps, 0);
                    m_ien[ch] = b[1:0];
                end
                5: begin
                    rreg(1, 4'd3, v); chk("R7 R8 random pend", v, exp_pend());
                    rreg(ch, 4'd0, v); chk("R11 random status", v, exp_stat(ch));
                end
                6: if (b[2:0] == 3'd0) begin
                    wreg(ch, 4'd9, {b[7:6], 6'b0}, ps);
                    if (b[6]) model_clear(0);
                    if (b[7]) model_clear(1);
                end
                default: @(negedge clk);
            endcase
            #1 chk("R6 random irq", irq, exp_irq());
        end

        // R12 mid-run reset
        event_pulse(2'b01, 16'h00AA, 2'b00, 2'b10);
        rst = 1; @(negedge clk); rst = 0;
        for (int c = 0; c < 2; c++) model_clear(c);
        #1 chk("R12 irq after mid reset", irq, 0);
        rreg(0, 4'd0, v); chk("R12 status after mid reset", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule